// File: doc/BRIEF.md
# Split-Tree Global Path Sorter

This block sits in the reconciliation stage of a split-tree list decoder for polar codes. Several sub-decoders run side by side. Each one keeps two candidate sub-paths, and each sub-path has a metric (a signed value where larger means more likely) and the bit it just decided. The block forms every global path, one sub-path taken from each sub-decoder. It adds the four metrics of each global path and removes any path that breaks a frozen-bit rule. It then reports the best path and a cheap stand-in for the second-best path.

A global path is encoded as a combination index. Bit `s` of the index gives the sub-path (0 or 1) taken from sub-decoder `s`. The frozen pattern for each subcode is held in its own circular shift register, which is loaded serially before decoding starts. Each decoding level moves every register on by one position.

A small state machine has two states:
- `ST_LOAD` is entered at reset. In this state the registers accept configuration bits and level strobes are ignored. The transition `LOAD_TO_RUN` is taken when `cfg_done` is high.
- `ST_RUN` is where levels are processed. The transition `RUN_TO_LOAD` is taken when `cfg_en` is high, which returns the block to loading.

Top module: `gps_sorter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `res_valid`, `lvl_bypass`, `best_idx`, `best_metric`, `sec_idx` and `sec_metric` are all 0. The state is `ST_LOAD` and every frozen bit is 0 (free).
- R2: In `ST_LOAD`, a cycle with `cfg_en` high shifts `cfg_bit` into the register chosen by `cfg_sel`. After FLEN such shifts, the first bit shifted in is the frozen bit used at the first level, and only the newest FLEN bits are kept. `cfg_done` moves the block to `ST_RUN` at the next edge. In `ST_RUN`, `cfg_en` high returns the block to `ST_LOAD`; that cycle neither shifts a bit nor processes a level.
- R3: The global metric of combination `c` is the sum of the metric of sub-path `c[s]` of every sub-decoder `s`. Sub-path `p` of sub-decoder `s` occupies the metric field starting at bit `(2*s+p)*MW` of `sp_metric` and bit `2*s+p` of `sp_bit`.
- R4: A combination is invalid when any sub-decoder whose current frozen bit is 1 contributes a sub-path whose decided bit is 1. The metric of an invalid combination is forced to the most negative value that fits in MW+log2(NSUB) bits.
- R5: A `lvl_valid` pulse in `ST_RUN` on a level that is not fully frozen raises `res_valid` for one cycle after the next edge. With it, `best_metric` and `best_idx` give the largest global metric. When metrics tie, the lowest combination index wins.
- R6: `sec_metric` and `sec_idx` give the best combination in the half of the index space (split on the top index bit) that does not hold the winner, with ties going to the lower index.
- R7: Every accepted level moves each frozen register forward by one position, including bypassed levels, so the pattern repeats every FLEN levels.
- R8: When the current frozen bits of all sub-decoders are 1, a level raises `lvl_bypass` for one cycle instead of `res_valid`. The result outputs keep their previous values.
- R9: A `lvl_valid` pulse in `ST_LOAD` produces no output pulse and does not move the frozen registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift a configuration bit (`ST_LOAD`) or return to loading (`ST_RUN`) |
| cfg_sel | input | log2(NSUB) | Frozen register chosen for the shift |
| cfg_bit | input | 1 | Serial frozen bit, 1 = frozen |
| cfg_done | input | 1 | Leave loading and start decoding |
| lvl_valid | input | 1 | Metrics for one decoding level are present |
| sp_metric | input | NSUB*2*MW | Signed sub-path metrics |
| sp_bit | input | NSUB*2 | Bit decided by each sub-path |
| res_valid | output | 1 | Sort result is valid |
| lvl_bypass | output | 1 | Level was fully frozen and the sort was skipped |
| best_idx | output | NSUB | Combination index of the best path |
| best_metric | output | MW+log2(NSUB) | Global metric of the best path |
| sec_idx | output | NSUB | Combination index of the runner-up |
| sec_metric | output | MW+log2(NSUB) | Global metric of the runner-up |

## Verification
The bench builds the block with four sub-decoders, 10-bit metrics and frozen registers of length 8. The short registers let the frozen pattern wrap several times within a short run, so every column (including a fully frozen one) comes round repeatedly. The narrow metrics make it possible to reach the sum where four minimum metrics land exactly on the forced invalid value. There, ties across all sixteen combinations decide both winners. Levels sent during loading and a return to loading in the middle of decoding are also driven, with a behavioural model compared against the outputs on every cycle.

// File: rtl/gps_pkg.sv
package gps_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } gps_state_e;

    localparam int unsigned GPS_NSUB_DEF = 4;
    localparam int unsigned GPS_MW_DEF   = 10;
    localparam int unsigned GPS_FLEN_DEF = 256;
endpackage

// File: rtl/gps_frz_ring.sv
module gps_frz_ring #(
    parameter int unsigned LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    input  logic adv,
    output logic cur
);
    logic [LEN-1:0] ring;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring <= '0;
        end else if (load) begin
            ring <= {load_bit, ring[LEN-1:1]};
        end else if (adv) begin
            ring <= {ring[0], ring[LEN-1:1]};
        end
    end

    assign cur = ring[0];
endmodule

// File: rtl/gps_combine.sv
module gps_combine #(
    parameter int unsigned NSUB = 4,
    parameter int unsigned MW   = 10,
    localparam int unsigned SW  = MW + $clog2(NSUB),
    localparam int unsigned NC  = 1 << NSUB
) (
    input  logic [NSUB*2*MW-1:0] sp_metric,
    input  logic [NSUB*2-1:0]    sp_bit,
    input  logic [NSUB-1:0]      frz,
    output logic [NC*SW-1:0]     gm
);
    localparam logic [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};

    always_comb begin
        gm = '0;
        for (int c = 0; c < NC; c++) begin
            logic [SW-1:0] acc;
            logic          ok;
            acc = '0;
            ok  = 1'b1;
            for (int s = 0; s < NSUB; s++) begin
                logic [MW-1:0] m;
                int unsigned   p;
                p = (c >> s) & 1;
                m = sp_metric[(2*s+p)*MW +: MW];
                acc = acc + {{(SW-MW){m[MW-1]}}, m};
                if (frz[s] && sp_bit[2*s+p]) ok = 1'b0;
            end
            gm[c*SW +: SW] = ok ? acc : MINV;
        end
    end
endmodule

// File: rtl/gps_cmp_tree.sv
module gps_cmp_tree #(
    parameter int unsigned NSUB = 4,
    parameter int unsigned SW   = 12,
    localparam int unsigned NC  = 1 << NSUB
) (
    input  logic [NC*SW-1:0]   gm,
    output logic [SW-1:0]      best_m,
    output logic [NSUB-1:0]    best_i,
    output logic [SW-1:0]      sec_m,
    output logic [NSUB-1:0]    sec_i
);
    logic signed [SW-1:0] hv [1:2*NC-1];
    logic [NSUB-1:0]      hi [1:2*NC-1];

    for (genvar l = 0; l < NC; l++) begin : g_leaf
        assign hv[NC+l] = gm[l*SW +: SW];
        assign hi[NC+l] = NSUB'(l);
    end

    for (genvar n = 1; n < NC; n++) begin : g_node
        logic left_wins;
        assign left_wins = (hv[2*n] >= hv[2*n+1]);
        assign hv[n] = left_wins ? hv[2*n] : hv[2*n+1];
        assign hi[n] = left_wins ? hi[2*n] : hi[2*n+1];
    end

    logic top_left;
    assign top_left = (hv[2] >= hv[3]);
    assign best_m = hv[1];
    assign best_i = hi[1];
    assign sec_m  = top_left ? hv[3] : hv[2];
    assign sec_i  = top_left ? hi[3] : hi[2];
endmodule

// File: rtl/gps_sorter.sv
module gps_sorter #(
    parameter int unsigned NSUB = gps_pkg::GPS_NSUB_DEF,
    parameter int unsigned MW   = gps_pkg::GPS_MW_DEF,
    parameter int unsigned FLEN = gps_pkg::GPS_FLEN_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_en,
    input  logic [$clog2(NSUB)-1:0]           cfg_sel,
    input  logic                              cfg_bit,
    input  logic                              cfg_done,
    input  logic                              lvl_valid,
    input  logic [NSUB*2*MW-1:0]              sp_metric,
    input  logic [NSUB*2-1:0]                 sp_bit,
    output logic                              res_valid,
    output logic                              lvl_bypass,
    output logic [NSUB-1:0]                   best_idx,
    output logic [MW+$clog2(NSUB)-1:0]        best_metric,
    output logic [NSUB-1:0]                   sec_idx,
    output logic [MW+$clog2(NSUB)-1:0]        sec_metric
);
    import gps_pkg::*;

    localparam int unsigned SW = MW + $clog2(NSUB);
    localparam int unsigned NC = 1 << NSUB;

    gps_state_e st, st_nx;
    logic       load_any, advance, all_frz;
    logic [NSUB-1:0] frz;
    logic [NC*SW-1:0] gm;
    logic [SW-1:0]    t_best_m, t_sec_m;
    logic [NSUB-1:0]  t_best_i, t_sec_i;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOAD: if (cfg_done) st_nx = ST_RUN;
            ST_RUN:  if (cfg_en)   st_nx = ST_LOAD;
            default: st_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    assign load_any = (st == ST_LOAD) && cfg_en;
    assign advance  = (st == ST_RUN) && !cfg_en && lvl_valid;
    assign all_frz  = &frz;

    for (genvar s = 0; s < NSUB; s++) begin : g_ring
        gps_frz_ring #(.LEN(FLEN)) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_any && (cfg_sel == s[$clog2(NSUB)-1:0])),
            .load_bit (cfg_bit),
            .adv      (advance),
            .cur      (frz[s])
        );
    end

    gps_combine #(.NSUB(NSUB), .MW(MW)) u_comb (
        .sp_metric (sp_metric),
        .sp_bit    (sp_bit),
        .frz       (frz),
        .gm        (gm)
    );

    gps_cmp_tree #(.NSUB(NSUB), .SW(SW)) u_tree (
        .gm     (gm),
        .best_m (t_best_m),
        .best_i (t_best_i),
        .sec_m  (t_sec_m),
        .sec_i  (t_sec_i)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            lvl_bypass  <= 1'b0;
            best_idx    <= '0;
            best_metric <= '0;
            sec_idx     <= '0;
            sec_metric  <= '0;
        end else begin
            res_valid  <= 1'b0;
            lvl_bypass <= 1'b0;
            if (advance) begin
                if (all_frz) begin
                    lvl_bypass <= 1'b1;
                end else begin
                    res_valid   <= 1'b1;
                    best_idx    <= t_best_i;
                    best_metric <= t_best_m;
                    sec_idx     <= t_sec_i;
                    sec_metric  <= t_sec_m;
                end
            end
        end
    end
endmodule

// File: rtl/gps_sorter_chk.sv
module gps_sorter_chk #(
    parameter int unsigned NSUB = 4,
    parameter int unsigned MW   = 10,
    parameter int unsigned FLEN = 256
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lvl_valid,
    input logic                       cfg_en,
    input gps_pkg::gps_state_e        st,
    input logic                       res_valid,
    input logic                       lvl_bypass,
    input logic [NSUB-1:0]            best_idx,
    input logic [MW+$clog2(NSUB)-1:0] best_metric,
    input logic [NSUB-1:0]            sec_idx,
    input logic [MW+$clog2(NSUB)-1:0] sec_metric
);
    // R5
    res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(lvl_valid) && !$past(cfg_en) && $past(st) == gps_pkg::ST_RUN));

    // R6
    sec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($signed(best_metric) >= $signed(sec_metric)));

    // R6
    sec_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (best_idx[NSUB-1] != sec_idx[NSUB-1]));

    // R8
    bypass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_bypass |-> !res_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(best_metric) && $stable(best_idx) &&
                        $stable(sec_metric) && $stable(sec_idx)));

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == gps_pkg::ST_LOAD) |=> (!res_valid && !lvl_bypass));
endmodule

bind gps_sorter gps_sorter_chk #(.NSUB(NSUB), .MW(MW), .FLEN(FLEN)) u_chk (.*);

// File: tb/gps_sorter_tb.sv
module gps_sorter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB = 4;
    localparam int MW   = 10;
    localparam int FLEN = 8;
    localparam int SW   = MW + 2;
    localparam int NC   = 16;
    localparam int MINV = -(1 << (SW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_done = 1'b0, lvl_valid = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [NSUB*2*MW-1:0] sp_metric = '0;
    logic [NSUB*2-1:0] sp_bit = '0;
    logic res_valid, lvl_bypass;
    logic [NSUB-1:0] best_idx, sec_idx;
    logic [SW-1:0] best_metric, sec_metric;

    always #(CLK_PERIOD/2) clk = ~clk;

    gps_sorter #(.NSUB(NSUB), .MW(MW), .FLEN(FLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
        .cfg_bit(cfg_bit), .cfg_done(cfg_done), .lvl_valid(lvl_valid),
        .sp_metric(sp_metric), .sp_bit(sp_bit), .res_valid(res_valid),
        .lvl_bypass(lvl_bypass), .best_idx(best_idx), .best_metric(best_metric),
        .sec_idx(sec_idx), .sec_metric(sec_metric)
    );

    int checks = 0, errors = 0, cycles = 0;
    string cur_tag = "R5";
    int mt [NSUB][2];
    bit bt [NSUB][2];
    int unsigned seed = 32'h1234_5678;

    // behavioural reference
    bit fq [NSUB][$];
    bit m_run = 0;
    bit e_valid = 0, e_byp = 0;
    int e_bm = 0, e_sm = 0, e_bi = 0, e_si = 0;

    task automatic model_reset();
        for (int s = 0; s < NSUB; s++) begin
            fq[s].delete();
            for (int k = 0; k < FLEN; k++) fq[s].push_back(1'b0);
        end
        m_run = 0; e_valid = 0; e_byp = 0;
        e_bm = 0; e_sm = 0; e_bi = 0; e_si = 0;
    endtask

    task automatic model_level();
        int gmv [NC];
        bit allf = 1;
        int lo_i = 0, hi_i = NC/2;
        for (int s = 0; s < NSUB; s++) allf &= fq[s][0];
        if (allf) begin
            e_byp = 1;
        end else begin
            for (int c = 0; c < NC; c++) begin
                int sum = 0;
                bit ok = 1;
                for (int s = 0; s < NSUB; s++) begin
                    int p = (c >> s) & 1;
                    sum += mt[s][p];
                    if (fq[s][0] && bt[s][p]) ok = 0;
                end
                gmv[c] = ok ? sum : MINV;
            end
            for (int c = 1; c < NC/2; c++) if (gmv[c] > gmv[lo_i]) lo_i = c;
            for (int c = NC/2+1; c < NC; c++) if (gmv[c] > gmv[hi_i]) hi_i = c;
            if (gmv[lo_i] >= gmv[hi_i]) begin
                e_bi = lo_i; e_si = hi_i;
            end else begin
                e_bi = hi_i; e_si = lo_i;
            end
            e_bm = gmv[e_bi]; e_sm = gmv[e_si];
            e_valid = 1;
        end
        for (int s = 0; s < NSUB; s++) begin
            bit x = fq[s].pop_front();
            fq[s].push_back(x);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            e_valid = 0; e_byp = 0;
            if (!m_run) begin
                if (cfg_en) begin
                    fq[cfg_sel].push_back(cfg_bit);
                    void'(fq[cfg_sel].pop_front());
                end
                if (cfg_done) m_run = 1;
            end else if (cfg_en) begin
                m_run = 0;
            end else if (lvl_valid) begin
                model_level();
            end
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        chk("R8", "res_valid", int'(res_valid), int'(e_valid));
        chk("R8", "lvl_bypass", int'(lvl_bypass), int'(e_byp));
        chk(cur_tag, "best_metric", int'($signed(best_metric)), e_bm);
        chk(cur_tag, "best_idx", int'(best_idx), e_bi);
        chk("R6", "sec_metric", int'($signed(sec_metric)), e_sm);
        chk("R6", "sec_idx", int'(sec_idx), e_si);
    endtask

    task automatic drive_paths();
        for (int s = 0; s < NSUB; s++)
            for (int p = 0; p < 2; p++) begin
                sp_metric[(2*s+p)*MW +: MW] = mt[s][p][MW-1:0];
                sp_bit[2*s+p] = bt[s][p];
            end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        cfg_en = 0; cfg_done = 0; lvl_valid = 0;
    endtask

    task automatic randomize_paths();
        for (int s = 0; s < NSUB; s++)
            for (int p = 0; p < 2; p++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                mt[s][p] = int'((seed >> 8) % 1024) - 512;
                bt[s][p] = seed[20];
            end
        drive_paths();
    endtask

    task automatic load_pattern(input logic [FLEN-1:0] pat [NSUB]);
        for (int s = 0; s < NSUB; s++)
            for (int k = 0; k < FLEN; k++) begin
                cfg_en = 1; cfg_sel = 2'(s); cfg_bit = pat[s][k];
                step();
            end
    endtask

    task automatic level();
        lvl_valid = 1;
        step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FLEN-1:0] patA [NSUB];
        logic [FLEN-1:0] patB [NSUB];
        patA[0] = 8'b0100_1011; patA[1] = 8'b0010_0101;
        patA[2] = 8'b1000_1001; patA[3] = 8'b0001_0011;
        patB[0] = 8'b1111_0000; patB[1] = 8'b1010_1010;
        patB[2] = 8'b0000_0000; patB[3] = 8'b0110_0110;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_tag = "R1";
        chk("R1", "reset res_valid", int'(res_valid), 0);
        chk("R1", "reset best_metric", int'(best_metric), 0);
        chk("R1", "reset sec_idx", int'(sec_idx), 0);
        rst_n = 1;
        step();

        // R9: levels during loading are ignored
        cur_tag = "R9";
        randomize_paths();
        level();
        level();

        // R2: serial load, then start
        cur_tag = "R2";
        load_pattern(patA);
        cfg_done = 1;
        step();

        // R3 R4 R7 R8: levels walk the pattern, wrapping several times
        cur_tag = "R3";
        for (int i = 0; i < 4*FLEN; i++) begin
            if (i == 2*FLEN) cur_tag = "R7";
            if (i[2]) begin
                for (int s = 0; s < NSUB; s++) begin bt[s][0] = 1; bt[s][1] = 1; end
                drive_paths();
                cur_tag = "R4";
            end else begin
                randomize_paths();
            end
            level();
            if (i % 3 == 0) step();
        end

        // R5: all metrics equal, ties go to the lowest index
        cur_tag = "R5";
        for (int i = 0; i < FLEN; i++) begin
            for (int s = 0; s < NSUB; s++) begin
                mt[s][0] = 7; mt[s][1] = 7; bt[s][0] = 0; bt[s][1] = 0;
            end
            drive_paths();
            level();
        end

        // R4: minimum metrics sum exactly to the forced invalid value
        cur_tag = "R4";
        for (int i = 0; i < FLEN; i++) begin
            for (int s = 0; s < NSUB; s++) begin
                mt[s][0] = -512; mt[s][1] = -512; bt[s][0] = 0; bt[s][1] = 1;
            end
            drive_paths();
            level();
        end

        // R2: return to loading mid-run, reload, continue
        cur_tag = "R2";
        cfg_en = 1;
        step();
        randomize_paths();
        level();
        load_pattern(patB);
        cfg_done = 1;
        step();
        cur_tag = "R7";
        for (int i = 0; i < 3*FLEN; i++) begin
            randomize_paths();
            level();
        end
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule